// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave

This block is the slave side of a two-wire serial memory. The model runs on a fast system clock and oversamples the serial clock and data lines. It watches for start and stop conditions and decodes a device address byte. It responds only when the three hardwired select inputs match the select bits in that byte. After the address it takes a two-byte word address. A write transaction then loads data bytes into a one-page buffer. That buffer is copied into the array by a self-timed internal cycle that begins at the stop condition. A read transaction returns bytes from the current address and advances the address after each byte.

The serial link carries all data, so the edge of the block has no valid/ready stream. The only back-pressure is a refusal to acknowledge. While the internal write cycle runs, the block does not acknowledge its own address. A host polls with address bytes until one is acknowledged. The data line is open-drain. The block only drives its pull-low enable, and the bus level comes back on a separate input. Incoming bits are sampled on the rising serial-clock edge, and the block's own drive changes only after a falling edge.

Top module: `serial_eeprom_slave`

## Requirements
- R1: A device address byte whose upper four bits are 1010 and whose bits 3..1 equal `chip_sel_i` is acknowledged. Bit 0 selects the direction: 0 is write, 1 is read. Any other byte gets no acknowledge, and the block then leaves the line released until the next start condition.
- R2: In a write transaction, the two bytes after the device address form the word address, high byte first. Both are acknowledged. A later read returns the byte stored at that address. Word-address bits above the array width are ignored, so the array aliases.
- R3: The block only ever pulls the data line low or releases it. Its pull enable becomes active only while the serial clock is low.
- R4: Data bytes in a write go to successive addresses. Only the low seven address bits increment, and they wrap from the last byte of the 128-byte page back to its first. The upper bits stay fixed.
- R5: A write of 1 to 128 bytes changes exactly the locations that were sent. Every other location keeps its value.
- R6: If `wp_i` is high when the stop condition of a write arrives, the array is left unchanged and no internal write cycle starts. Data bytes are still acknowledged.
- R7: When a write that carried data ends with a stop, an internal cycle of `WR_CYCLES` system clocks begins. During that cycle a matching device address is not acknowledged. Once the cycle ends, the address is acknowledged again.
- R8: Buffered bytes are committed only by a stop condition. A repeated start discards them. A write that sends only the word address starts no internal cycle.
- R9: In a read, each byte is sent most significant bit first. After each byte the address increments across page boundaries and rolls over from the last array location to location 0. A read that follows a write with no data starts at the word address that write sent.
- R10: When the host does not acknowledge a read byte, the block stops driving. It leaves the line released until the next start condition.
- R11: After reset the line is released, the block is idle and every array location reads 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock from the host |
| sda_i | input | 1 | Sampled level of the shared data line |
| sda_pull_o | output | 1 | High pulls the data line low, low releases it |
| chip_sel_i | input | 3 | Hardwired select value compared with the device address |
| wp_i | input | 1 | Write inhibit, sampled at the stop condition |

## Verification
The hardest window to reach is the internal write cycle. A poll has to land inside it and be refused. A later poll has to be accepted after it ends, and no stop outside a data write may start a cycle. The bench reaches this window by polling right after each data write, and it uses a short cycle length so that a refusal and then an acceptance both occur. Page-wrap writes that start near a page end, a repeated start after buffered data, and a read that crosses the last array location cover the remaining address corners.

// File: rtl/eep_pkg.sv
package eep_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_DEV, ST_ACKD, ST_AHI, ST_ACKH, ST_ALO, ST_ACKL,
    ST_WDAT, ST_ACKW, ST_RDAT, ST_RACK, ST_SKIP
  } eep_state_e;
  localparam logic [3:0] DEV_TYPE = 4'b1010;
  localparam int WORD_W = 16;
endpackage

// File: rtl/eep_line_sync.sv
module eep_line_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_m, sda_m, scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_m <= 1'b1; scl_s <= 1'b1; scl_q <= 1'b1;
      sda_m <= 1'b1; sda_s <= 1'b1; sda_q <= 1'b1;
    end else begin
      scl_m <= scl_i; scl_s <= scl_m; scl_q <= scl_s;
      sda_m <= sda_i; sda_s <= sda_m; sda_q <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/eep_page_buf.sv
module eep_page_buf #(
  parameter int PAGE_AW = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               wr_en,
  input  logic [PAGE_AW-1:0] wr_idx,
  input  logic [7:0]         wr_data,
  input  logic [PAGE_AW-1:0] rd_idx,
  output logic [7:0]         rd_data,
  output logic               rd_vld
);
  localparam int PAGE_BYTES = 1 << PAGE_AW;

  logic [7:0]            slot_q [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] mark_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mark_q <= '0;
    else if (clr) mark_q <= '0;
    else if (wr_en) mark_q[wr_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_en) slot_q[wr_idx] <= wr_data;
  end

  assign rd_data = slot_q[rd_idx];
  assign rd_vld  = mark_q[rd_idx];
endmodule

// File: rtl/eep_wr_timer.sv
module eep_wr_timer #(
  parameter int CYCLES = 500,
  parameter int IDX_W  = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  output logic             busy,
  output logic             step_vld,
  output logic [IDX_W-1:0] step_idx
);
  localparam int CW = $clog2(CYCLES + 1);
  localparam logic [CW-1:0] LAST  = CW'(CYCLES - 1);
  localparam logic [CW-1:0] STEPS = CW'(1 << IDX_W);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      cnt_q <= '0;
    end else if (busy) begin
      if (cnt_q == LAST) begin
        busy  <= 1'b0;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else if (go) begin
      busy  <= 1'b1;
      cnt_q <= '0;
    end
  end

  assign step_vld = busy && (cnt_q < STEPS);
  assign step_idx = cnt_q[IDX_W-1:0];

  // R7: a new cycle is only requested while the previous one has finished
  p_go_not_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> !busy);
endmodule

// File: rtl/eep_array.sv
module eep_array #(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  localparam int DEPTH = 1 << AW;

  logic [7:0] cell_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cell_q[i] <= 8'hFF;
    end else if (we) begin
      cell_q[waddr] <= wdata;
    end
  end

  assign rdata = cell_q[raddr];
endmodule

// File: rtl/serial_eeprom_slave.sv
module serial_eeprom_slave import eep_pkg::*; #(
  parameter int MEM_AW    = 10,
  parameter int PAGE_AW   = 7,
  parameter int WR_CYCLES = 2000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_pull_o,
  input  logic [2:0] chip_sel_i,
  input  logic       wp_i
);
  localparam int PAGE_BYTES = 1 << PAGE_AW;
  localparam int PG_W       = MEM_AW - PAGE_AW;
  localparam int WR_EFF     = (WR_CYCLES > PAGE_BYTES) ? WR_CYCLES : PAGE_BYTES + 1;

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

  eep_line_sync u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  eep_state_e        st_q;
  logic [2:0]        bit_cnt_q;
  logic              got8_q;
  logic [7:0]        rx_sh_q, tx_sh_q, hi_q;
  logic [WORD_W-1:0] word_q;
  logic              rw_q, dirty_q, ack_seen_q;
  logic [PG_W-1:0]   cpage_q;
  logic [7:0]        mem_rd, buf_rd;
  logic              busy, step_vld, buf_vld, arr_we, buf_wr, buf_clr, commit_go;
  logic [PAGE_AW-1:0] step_idx;
  logic              byte_in;
  logic              dev_hit;

  assign byte_in   = scl_fall && got8_q;
  assign dev_hit   = (rx_sh_q[7:4] == DEV_TYPE) && (rx_sh_q[3:1] == chip_sel_i) && !busy;
  assign buf_wr    = (st_q == ST_WDAT) && byte_in;
  assign buf_clr   = (st_q == ST_ALO) && byte_in;
  assign commit_go = stop_det && dirty_q && !wp_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; bit_cnt_q <= '0; got8_q <= 1'b0;
      rx_sh_q <= '0; tx_sh_q <= '0; hi_q <= '0; word_q <= '0;
      rw_q <= 1'b0; dirty_q <= 1'b0; ack_seen_q <= 1'b0;
      cpage_q <= '0; sda_pull_o <= 1'b0;
    end else if (start_det) begin
      st_q <= ST_DEV; bit_cnt_q <= '0; got8_q <= 1'b0;
      dirty_q <= 1'b0; sda_pull_o <= 1'b0;
    end else if (stop_det) begin
      st_q <= ST_IDLE; dirty_q <= 1'b0; sda_pull_o <= 1'b0;
      cpage_q <= word_q[MEM_AW-1:PAGE_AW];
    end else begin
      unique case (st_q)
        ST_DEV, ST_AHI, ST_ALO, ST_WDAT: begin
          if (scl_rise) begin
            rx_sh_q   <= {rx_sh_q[6:0], sda_s};
            bit_cnt_q <= bit_cnt_q + 3'd1;
            if (bit_cnt_q == 3'd7) got8_q <= 1'b1;
          end else if (byte_in) begin
            got8_q    <= 1'b0;
            bit_cnt_q <= '0;
            unique case (st_q)
              ST_DEV: begin
                if (dev_hit) begin
                  sda_pull_o <= 1'b1; rw_q <= rx_sh_q[0]; st_q <= ST_ACKD;
                end else begin
                  st_q <= ST_SKIP;
                end
              end
              ST_AHI: begin
                hi_q <= rx_sh_q; sda_pull_o <= 1'b1; st_q <= ST_ACKH;
              end
              ST_ALO: begin
                word_q <= {hi_q, rx_sh_q}; sda_pull_o <= 1'b1; st_q <= ST_ACKL;
              end
              default: begin
                word_q <= {word_q[WORD_W-1:PAGE_AW], word_q[PAGE_AW-1:0] + 1'b1};
                dirty_q <= 1'b1; sda_pull_o <= 1'b1; st_q <= ST_ACKW;
              end
            endcase
          end
        end
        ST_ACKD: begin
          if (scl_fall) begin
            if (rw_q) begin
              tx_sh_q <= mem_rd; sda_pull_o <= ~mem_rd[7];
              bit_cnt_q <= '0; st_q <= ST_RDAT;
            end else begin
              sda_pull_o <= 1'b0; st_q <= ST_AHI;
            end
          end
        end
        ST_ACKH: if (scl_fall) begin sda_pull_o <= 1'b0; st_q <= ST_ALO; end
        ST_ACKL, ST_ACKW: if (scl_fall) begin sda_pull_o <= 1'b0; st_q <= ST_WDAT; end
        ST_RDAT: begin
          if (scl_fall) begin
            if (bit_cnt_q == 3'd7) begin
              sda_pull_o <= 1'b0; word_q <= word_q + 1'b1; st_q <= ST_RACK;
            end else begin
              tx_sh_q <= {tx_sh_q[6:0], 1'b0}; sda_pull_o <= ~tx_sh_q[6];
              bit_cnt_q <= bit_cnt_q + 3'd1;
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) begin
            ack_seen_q <= ~sda_s;
          end else if (scl_fall) begin
            if (ack_seen_q) begin
              tx_sh_q <= mem_rd; sda_pull_o <= ~mem_rd[7];
              bit_cnt_q <= '0; st_q <= ST_RDAT;
            end else begin
              st_q <= ST_SKIP;
            end
          end
        end
        default: ;
      endcase
    end
  end

  eep_page_buf #(.PAGE_AW(PAGE_AW)) u_buf (
    .clk(clk), .rst_n(rst_n), .clr(buf_clr), .wr_en(buf_wr),
    .wr_idx(word_q[PAGE_AW-1:0]), .wr_data(rx_sh_q),
    .rd_idx(step_idx), .rd_data(buf_rd), .rd_vld(buf_vld)
  );

  eep_wr_timer #(.CYCLES(WR_EFF), .IDX_W(PAGE_AW)) u_timer (
    .clk(clk), .rst_n(rst_n), .go(commit_go),
    .busy(busy), .step_vld(step_vld), .step_idx(step_idx)
  );

  assign arr_we = step_vld && buf_vld;

  eep_array #(.AW(MEM_AW)) u_array (
    .clk(clk), .rst_n(rst_n), .we(arr_we),
    .waddr({cpage_q, step_idx}), .wdata(buf_rd),
    .raddr(word_q[MEM_AW-1:0]), .rdata(mem_rd)
  );

  // R3: the pull enable only turns on while the serial clock is low
  p_pull_scl_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull_o) |-> !scl_s);
  // R7: the address is never acknowledged during the internal cycle
  p_no_ack_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_ACKD) |-> !busy);
  // R4: page bits hold while a data byte advances the address
  p_page_fixed_r4: assert property (@(posedge clk) disable iff (!rst_n)
    buf_wr |=> word_q[WORD_W-1:PAGE_AW] == $past(word_q[WORD_W-1:PAGE_AW]));
  // R8: a cycle only starts after a stop that closes a data write
  p_cycle_from_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(stop_det && dirty_q));
  // R6: a cycle never starts with the write inhibit high
  p_cycle_unprotected_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(!wp_i));
  // R1: the block stays silent after an address mismatch
  p_skip_silent_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SKIP) |-> !sda_pull_o);
  // R10: the host acknowledge slot is never driven
  p_rack_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RACK) |-> !sda_pull_o);
endmodule

// File: tb/serial_eeprom_slave_test.sv
module serial_eeprom_slave_test;
  localparam int AW = 10;
  localparam int WRC = 500;
  localparam int Q = 4;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda_h = 1'b1, wp = 1'b0;
  logic [2:0] sel = 3'b101;
  logic pull, sda_line;
  logic [7:0] ref_mem [DEPTH];
  int checks = 0, fails = 0, cyc = 0;

  assign sda_line = sda_h & ~pull;
  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  serial_eeprom_slave #(.MEM_AW(AW), .PAGE_AW(7), .WR_CYCLES(WRC)) uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
    .sda_pull_o(pull), .chip_sel_i(sel), .wp_i(wp)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] devb(input logic [2:0] s, input logic rd);
    return {4'b1010, s, rd};
  endfunction

  function automatic int page_idx(input logic [15:0] a, input int k);
    logic [15:0] x;
    x = {a[15:7], a[6:0] + 7'(k)};
    return int'(x[AW-1:0]);
  endfunction

  function automatic int seq_idx(input logic [15:0] a, input int k);
    return (int'(a) + k) % DEPTH;
  endfunction

  task automatic bus_start();
    sda_h = 1'b1; tick(Q); scl = 1'b1; tick(Q);
    sda_h = 1'b0; tick(Q); scl = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_h = 1'b0; tick(Q); scl = 1'b1; tick(Q); sda_h = 1'b1; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_h = b[i]; tick(Q); scl = 1'b1; tick(2 * Q); scl = 1'b0; tick(Q);
    end
    sda_h = 1'b1; tick(Q); scl = 1'b1; tick(Q);
    ack = !sda_line;
    tick(Q); scl = 1'b0; tick(Q);
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] b);
    sda_h = 1'b1; b = '0;
    for (int i = 0; i < 8; i++) begin
      tick(Q); scl = 1'b1; tick(Q); b = {b[6:0], sda_line}; tick(Q); scl = 1'b0; tick(Q);
    end
    sda_h = give_ack ? 1'b0 : 1'b1; tick(Q); scl = 1'b1; tick(2 * Q); scl = 1'b0; tick(Q);
    sda_h = 1'b1;
  endtask

  task automatic do_write(input logic [15:0] a, input int n, input bit wpv, input string req);
    bit ak; int ok = 1; logic [7:0] d;
    wp = wpv;
    bus_start();
    send_byte(devb(sel, 1'b0), ak); if (!ak) ok = 0;
    send_byte(a[15:8], ak); if (!ak) ok = 0;
    send_byte(a[7:0], ak); if (!ak) ok = 0;
    for (int k = 0; k < n; k++) begin
      d = 8'($urandom);
      send_byte(d, ak); if (!ak) ok = 0;
      if (!wpv) ref_mem[page_idx(a, k)] = d;
    end
    bus_stop();
    chk(req, ok, 1);
  endtask

  task automatic wait_ready(output int polls);
    bit ak; bit done = 1'b0;
    polls = 0;
    while (!done && polls < 200) begin
      bus_start(); send_byte(devb(sel, 1'b0), ak); bus_stop();
      if (ak) done = 1'b1; else polls++;
    end
  endtask

  task automatic do_read(input logic [15:0] a, input int n, input string req);
    bit ak; logic [7:0] b;
    bus_start();
    send_byte(devb(sel, 1'b0), ak);
    send_byte(a[15:8], ak);
    send_byte(a[7:0], ak);
    bus_start();
    send_byte(devb(sel, 1'b1), ak);
    chk({req, " read address ack"}, ak, 1);
    for (int k = 0; k < n; k++) begin
      recv_byte(k < n - 1, b);
      chk(req, b, ref_mem[seq_idx(a, k)]);
    end
    bus_stop();
  endtask

  initial begin
    wait (cyc >= 190000);
    fails++;
    $display("FAIL watchdog actual=%0d expected=finished", cyc);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int polls, dummy;
    bit ak;
    logic [7:0] b;
    dummy = int'($urandom(32'h5EED_0042));
    for (int i = 0; i < DEPTH; i++) ref_mem[i] = 8'hFF;
    tick(10); rst_n = 1'b1; tick(10);

    // R11: released line and erased contents after reset
    chk("R11 pull after reset", pull, 0);
    do_read(16'h0000, 4, "R11 erased read");

    // R1: select mismatch and wrong type are ignored
    bus_start(); send_byte(devb(sel ^ 3'b010, 1'b0), ak); chk("R1 wrong select", ak, 0);
    send_byte(8'h00, ak); chk("R1 silent until start", ak, 0); bus_stop();
    bus_start(); send_byte({4'b1011, sel, 1'b0}, ak); chk("R1 wrong type", ak, 0); bus_stop();

    // R2 R5 R7: short write, poll during the internal cycle, read back with neighbours
    do_write(16'h0010, 5, 1'b0, "R2 write acks");
    wait_ready(polls);
    chk("R7 refused while busy", polls > 0, 1);
    chk("R7 accepted afterwards", polls < 20, 1);
    do_read(16'h000E, 9, "R5 partial page");

    // R4: write near a page end wraps to the page start
    do_write(16'h007D, 6, 1'b0, "R4 wrap write acks");
    wait_ready(polls);
    do_read(16'h007C, 6, "R4 wrap tail");
    do_read(16'h0000, 4, "R4 wrap head");

    // R6: protected write leaves array alone and starts no cycle
    do_write(16'h0200, 4, 1'b1, "R6 protected acks");
    wp = 1'b0;
    wait_ready(polls);
    chk("R6 no busy cycle", polls, 0);
    do_read(16'h0200, 4, "R6 contents kept");

    // R8: repeated start drops buffered bytes
    bus_start(); send_byte(devb(sel, 1'b0), ak);
    send_byte(8'h03, ak); send_byte(8'h00, ak);
    send_byte(8'h5A, ak); send_byte(8'hA5, ak);
    bus_start(); send_byte(devb(sel, 1'b0), ak); bus_stop();
    wait_ready(polls);
    chk("R8 no cycle after restart", polls, 0);
    do_read(16'h0300, 2, "R8 nothing committed");

    // R9: read across the last location into location 0
    do_write(16'h03FE, 2, 1'b0, "R9 tail write acks");
    wait_ready(polls);
    do_read(16'h03FE, 5, "R9 rollover read");
    do_read(16'h007E, 4, "R9 cross page read");

    // R10: after host NACK, the line stays released
    bus_start(); send_byte(devb(sel, 1'b0), ak);
    send_byte(8'h00, ak); send_byte(8'h10, ak);
    bus_start(); send_byte(devb(sel, 1'b1), ak);
    recv_byte(1'b0, b); chk("R10 first byte", b, ref_mem[16]);
    recv_byte(1'b0, b); chk("R10 released after nack", b, 8'hFF);
    bus_stop();

    // R2 R4 R5 R9: random writes and reads, upper address bits alias
    for (int it = 0; it < 12; it++) begin
      logic [15:0] a; int n;
      a = 16'($urandom); n = 1 + int'($urandom % 20);
      do_write(a, n, 1'b0, "R2 random write acks");
      wait_ready(polls);
      do_read(16'($urandom), 1 + int'($urandom % 12), "R9 random read");
      do_read({a[15:7], 7'd0} + 16'(a[6:0]), n, "R4 random page read");
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule